// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the shared external bus of an 8-bit controller core whose program store is entirely off-chip. It is clocked by the oscillator. It splits every machine cycle into twelve one-period slots and produces the address-latch strobe, the active-low program-read strobe, and the active-low data read and write strobes. It also drives the multiplexed low address/data port and the high address port. The high port is the upper address byte, or the core's port-2 register during register-addressed data moves.

The block keeps its own fetch pointer and fetches one byte in each half of a machine cycle. The core can redirect the pointer at the start of any fetch half. It can also request a data move; the block samples that request only as a machine cycle begins. A data-move cycle latches its address once. It gives up the second latch pulse and both program-read pulses to make room for a six-slot read or write strobe. Fetched bytes are returned with their addresses, and read bytes are returned on a separate result port.

Top module: `xbus_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `p0_oe`=0, `p0_out`=FFh, `p2_out`=FFh, and both valid outputs are 0.
- R2: The first machine cycle begins at the first clock edge after `rst` falls. Slots are numbered 0 to 11. In a fetch cycle `ale` is high in slots 0, 1, 6 and 7, and `psen_n` is low in slots 3 to 5 and 9 to 11.
- R3: In each fetch half the low address byte is driven on `p0_out` with `p0_oe`=1 during the first three slots of the half, and `p0_oe`=0 while `psen_n` is low. `p2_out` carries address bits 15 to 8 for the whole half.
- R4: After reset the first fetch reads address 0000h. Each following fetch reads the previous fetch address plus one, wrapping at FFFFh.
- R5: When `pc_load` is high at the edge that begins a fetch half, that half fetches `pc_target`, and later fetches continue from `pc_target`+1.
- R6: The byte on `p0_in` during the last program-read slot of a half is captured. It appears on `instr_data`, with its address on `instr_addr` and `instr_valid` high, for exactly the cycle after `psen_n` rises.
- R7: `req_valid` is sampled only at the edge that begins a machine cycle. If it is set, that cycle is a data cycle: `req_ack` is high in slot 0, `ale` is high only in slots 0 and 1, `psen_n` stays high, and the fetch pointer does not move.
- R8: In a data cycle exactly one strobe is low in slots 5 to 10: `wr_n` when `req_write`=1 and `rd_n` when it is 0.
- R9: In a write cycle `p0_out` carries `req_wdata` with `p0_oe`=1 in slots 3 to 11.
- R10: In a read cycle `p0_oe`=0 in slots 3 to 11. The byte on `p0_in` in slot 10 appears on `rd_data`, with `rd_valid` high, in slot 11.
- R11: In a data cycle `p2_out` carries `req_addr[15:8]` when `req_wide`=1 and the `p2_reg` input when `req_wide`=0.
- R12: In a data cycle `p0_out` carries `req_addr[7:0]` with `p0_oe`=1 in slots 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one slot per period |
| rst | input | 1 | Synchronous reset, active high |
| pc_load | input | 1 | Redirect the fetch pointer at the next fetch-half start |
| pc_target | input | ADDR_W (16) | New fetch address |
| req_valid | input | 1 | Data-move request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = full pointer address, 0 = register address with high port from `p2_reg` |
| req_addr | input | ADDR_W (16) | Data-move address |
| req_wdata | input | DATA_W (8) | Write byte |
| p2_reg | input | ADDR_W-DATA_W (8) | Port-2 register contents |
| req_ack | output | 1 | High in slot 0 of an accepted data cycle |
| instr_valid | output | 1 | Fetched byte available |
| instr_addr | output | ADDR_W (16) | Address of the fetched byte |
| instr_data | output | DATA_W (8) | Fetched byte |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | DATA_W (8) | Read byte |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Program-read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | DATA_W (8) | Multiplexed low address / data out |
| p0_oe | output | 1 | Drive enable for the multiplexed port |
| p0_in | input | DATA_W (8) | Multiplexed port input |
| p2_out | output | ADDR_W-DATA_W (8) | High address port |

## Verification
The hardest cases are the ones where a machine-cycle boundary coincides with something else. One is a data request that arrives just as a fetch cycle is ending. Another is a redirect that moves the pointer to FFFFh and then lets it wrap. A third is a fetched byte from a second half that is returned during slot 0 of the following data cycle. A vector table sets up each request in the last slot of the previous cycle so that every vector lands on a cycle start. It interleaves fetch, wide and narrow reads and writes, and wrapping redirects. `p0_in` is driven with the expected byte only in the single capture slot and with a decoy byte in every other slot, so a capture one slot early or late is caught.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int SLOTS      = 12;
  localparam int HALF       = SLOTS / 2;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int ALE_SLOTS  = 2;
  localparam int ADDR_SLOTS = 3;
  localparam int STB_FIRST  = 5;
  localparam int STB_LAST   = 10;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef enum logic {KIND_FETCH = 1'b0, KIND_DATA = 1'b1} kind_e;

  // position inside the current half of the machine cycle
  function automatic int unsigned half_pos(slot_t s);
    return (int'(s) >= HALF) ? int'(s) - HALF : int'(s);
  endfunction

  function automatic logic want_ale(slot_t s, kind_e k);
    if (k == KIND_DATA) return (int'(s) < ALE_SLOTS);
    return (half_pos(s) < ALE_SLOTS);
  endfunction

  function automatic logic want_psen(slot_t s, kind_e k);
    return (k == KIND_FETCH) && (half_pos(s) >= ADDR_SLOTS);
  endfunction

  function automatic logic want_strobe(slot_t s, kind_e k);
    return (k == KIND_DATA) && (int'(s) >= STB_FIRST) && (int'(s) <= STB_LAST);
  endfunction

  function automatic logic want_addr(slot_t s, kind_e k);
    if (k == KIND_DATA) return (int'(s) < ADDR_SLOTS);
    return (half_pos(s) < ADDR_SLOTS);
  endfunction

  // edge on which the incoming byte is taken: last slot with strobe active
  function automatic logic want_capture(slot_t s, kind_e k, logic wr);
    if (k == KIND_FETCH) return (half_pos(s) == HALF - 1);
    return !wr && (int'(s) == STB_LAST);
  endfunction
endpackage

// File: rtl/xbus_slot_timer.sv
module xbus_slot_timer
  import xbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_t slot,
  output logic  run,
  output logic  cyc_start,
  output logic  half_start
);
  localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);
  localparam slot_t MID_SLOT  = slot_t'(HALF - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      slot <= '0;
    end else if (!run) begin
      run  <= 1'b1;
      slot <= '0;
    end else if (slot == LAST_SLOT) begin
      slot <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  // high on the edge that opens slot 0 / slot HALF
  assign cyc_start  = !run || (slot == LAST_SLOT);
  assign half_start = run && (slot == MID_SLOT);

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && slot == LAST_SLOT) |=> (slot == '0)); // R2
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (int'(slot) < SLOTS)); // R2
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              half_start,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_target,
  output kind_e             kind,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wide,
  output logic              write,
  output logic [DATA_W-1:0] wdata
);
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] fetch_pick;
  logic              fetch_open;

  assign fetch_pick = pc_load ? pc_target : pc;
  assign fetch_open = cyc_start || (half_start && kind == KIND_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind     <= KIND_FETCH;
      cur_addr <= '0;
      pc       <= '0;
      wide     <= 1'b1;
      write    <= 1'b0;
      wdata    <= '0;
    end else if (cyc_start && req_valid) begin
      kind     <= KIND_DATA;
      cur_addr <= req_addr;
      wide     <= req_wide;
      write    <= req_write;
      wdata    <= req_wdata;
    end else if (fetch_open) begin
      kind     <= KIND_FETCH;
      cur_addr <= fetch_pick;
      pc       <= fetch_pick + 1'b1;
      wide     <= 1'b1;
      write    <= 1'b0;
    end
  end

  AST_FETCH_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (half_start && kind == KIND_FETCH && !pc_load) |=> (cur_addr == $past(cur_addr) + 1'b1)); // R4
endmodule

// File: rtl/xbus_pin_decode.sv
module xbus_pin_decode
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  slot_t                    slot,
  input  kind_e                    kind,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic                     wide,
  input  logic                     write,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [ADDR_W-DATA_W-1:0] p2_reg,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        p0_out,
  output logic                     p0_oe,
  output logic [ADDR_W-DATA_W-1:0] p2_out
);
  logic addr_ph;
  logic wr_ph;
  logic strobe;

  always_comb begin
    ale     = 1'b0;
    psen_n  = 1'b1;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    p0_oe   = 1'b0;
    p0_out  = '1;
    p2_out  = '1;
    addr_ph = 1'b0;
    wr_ph   = 1'b0;
    strobe  = 1'b0;
    if (run) begin
      addr_ph = want_addr(slot, kind);
      wr_ph   = (kind == KIND_DATA) && write;
      strobe  = want_strobe(slot, kind);
      ale     = want_ale(slot, kind);
      psen_n  = !want_psen(slot, kind);
      rd_n    = !(strobe && !write);
      wr_n    = !(strobe && write);
      p0_oe   = addr_ph || wr_ph;
      if (addr_ph)    p0_out = cur_addr[DATA_W-1:0];
      else if (wr_ph) p0_out = wdata;
      p2_out  = (kind == KIND_DATA && !wide) ? p2_reg : cur_addr[ADDR_W-1:DATA_W];
    end
  end

  AST_ALE_PSEN_EXCL: assert property (@(posedge clk) disable iff (rst)
    ale |-> psen_n); // R2
  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(ale) && !$past(rst)) |-> $past(ale, 2)); // R2
  AST_PSEN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> !p0_oe); // R3
  AST_STROBE_NO_PSEN: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> psen_n); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> wr_n); // R8
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> p0_oe); // R9
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !p0_oe); // R10
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  slot_t             slot,
  input  kind_e             kind,
  input  logic              write,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] p0_in,
  output logic              instr_valid,
  output logic [ADDR_W-1:0] instr_addr,
  output logic [DATA_W-1:0] instr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic grab_fetch;
  logic grab_read;

  assign grab_fetch = run && (kind == KIND_FETCH) && want_capture(slot, kind, write);
  assign grab_read  = run && (kind == KIND_DATA)  && want_capture(slot, kind, write);

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_valid <= 1'b0;
      instr_addr  <= '0;
      instr_data  <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      instr_valid <= grab_fetch;
      rd_valid    <= grab_read;
      if (grab_fetch) begin
        instr_addr <= cur_addr;
        instr_data <= p0_in;
      end
      if (grab_read) rd_data <= p0_in;
    end
  end
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pc_load,
  input  logic [ADDR_W-1:0]        pc_target,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_wide,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [ADDR_W-DATA_W-1:0] p2_reg,
  output logic                     req_ack,
  output logic                     instr_valid,
  output logic [ADDR_W-1:0]        instr_addr,
  output logic [DATA_W-1:0]        instr_data,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        p0_out,
  output logic                     p0_oe,
  input  logic [DATA_W-1:0]        p0_in,
  output logic [ADDR_W-DATA_W-1:0] p2_out
);
  slot_t             slot;
  logic              run;
  logic              cyc_start;
  logic              half_start;
  kind_e             kind;
  logic [ADDR_W-1:0] cur_addr;
  logic              wide;
  logic              write;
  logic [DATA_W-1:0] wdata;

  xbus_slot_timer u_timer (
    .clk(clk), .rst(rst), .slot(slot), .run(run),
    .cyc_start(cyc_start), .half_start(half_start)
  );

  xbus_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .half_start(half_start),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .pc_load(pc_load), .pc_target(pc_target),
    .kind(kind), .cur_addr(cur_addr), .wide(wide), .write(write), .wdata(wdata)
  );

  xbus_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .run(run), .slot(slot), .kind(kind),
    .cur_addr(cur_addr), .wide(wide), .write(write), .wdata(wdata), .p2_reg(p2_reg),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
  );

  xbus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .run(run), .slot(slot), .kind(kind), .write(write),
    .cur_addr(cur_addr), .p0_in(p0_in),
    .instr_valid(instr_valid), .instr_addr(instr_addr), .instr_data(instr_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign req_ack = run && (slot == '0) && (kind == KIND_DATA);

  AST_INSTR_ON_PSEN_END: assert property (@(posedge clk) disable iff (rst)
    ($rose(psen_n) && !$past(rst)) |-> instr_valid); // R6
  AST_RDVALID_ON_STROBE_END: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) && !$past(rst)) |-> rd_valid); // R10
  AST_ACK_NO_ALE_SKIP: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> ale); // R7
endmodule

// File: tb/test_xbus_sequencer.sv
module test_xbus_sequencer;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int NVEC = 9;
  // [27] data  [26] write  [25] wide  [24] redirect  [23:8] address/target  [7:0] write byte
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'hABCD, 8'h00},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h0056, 8'h9A},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'h00F0, 8'h00},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 8'h5A},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, pc_load, req_valid, req_write, req_wide;
  logic [AW-1:0] pc_target, req_addr;
  logic [DW-1:0] req_wdata, p0_in;
  logic [AW-DW-1:0] p2_reg;
  logic req_ack, instr_valid, rd_valid, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [AW-1:0] instr_addr;
  logic [DW-1:0] instr_data, rd_data, p0_out;
  logic [AW-DW-1:0] p2_out;

  xbus_sequencer #(.ADDR_W(AW), .DATA_W(DW)) i_xbus_sequencer (
    .clk(clk), .rst(rst), .pc_load(pc_load), .pc_target(pc_target),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .p2_reg(p2_reg),
    .req_ack(req_ack), .instr_valid(instr_valid), .instr_addr(instr_addr),
    .instr_data(instr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic drive_vec(input logic [27:0] v);
    req_valid = v[27];
    req_write = v[26];
    req_wide  = v[25];
    pc_load   = v[24];
    pc_target = v[23:8];
    req_addr  = v[23:8];
    req_wdata = v[7:0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pcm, a0, a1, ea, pend_a;
    logic pend;
    rst = 1'b1;
    drive_vec('0);
    p2_reg = 8'h77;
    p0_in = 8'hEE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ale", 16'(ale), 16'h0);
    chk("R1 psen_n", 16'(psen_n), 16'h1);
    chk("R1 rd_n", 16'(rd_n), 16'h1);
    chk("R1 wr_n", 16'(wr_n), 16'h1);
    chk("R1 p0_oe", 16'(p0_oe), 16'h0);
    chk("R1 p0_out", 16'(p0_out), 16'hFF);
    chk("R1 p2_out", 16'(p2_out), 16'hFF);
    chk("R1 instr_valid", 16'(instr_valid), 16'h0);
    chk("R1 rd_valid", 16'(rd_valid), 16'h0);

    drive_vec(VEC[0]);
    rst = 1'b0;
    pcm = 16'h0000;
    pend = 1'b0;
    pend_a = '0;
    for (int v = 0; v < NVEC; v++) begin
      logic [27:0] vec;
      logic isd, wr, wide, ld;
      logic [15:0] ad;
      vec = VEC[v];
      isd = vec[27]; wr = vec[26]; wide = vec[25]; ld = vec[24]; ad = vec[23:8];
      a0 = '0; a1 = '0;
      if (!isd) begin
        a0 = ld ? ad : pcm;
        a1 = a0 + 16'h1;
        pcm = a1 + 16'h1;
      end
      for (int s = 0; s < 12; s++) begin
        int hp;
        logic e_ale, e_ps, e_rd, e_wr, e_oe, addrph, strobe;
        logic [7:0] e_p0, e_p2;
        string t_sl, t_oe, t_p0, t_p2;
        @(negedge clk);
        hp = (s >= 6) ? s - 6 : s;
        if (s == 0) begin
          chk("R7 req_ack", 16'(req_ack), 16'(isd));
          if (pend) begin
            chk("R6 instr_valid second half", 16'(instr_valid), 16'h1);
            chk("R6 instr_addr second half", instr_addr, pend_a);
            chk("R6 instr_data second half", 16'(instr_data), 16'(mem(pend_a)));
            pend = 1'b0;
          end
          req_valid = 1'b0;
          pc_load = 1'b0;
        end
        if (isd) begin
          ea = ad;
          e_ale = (s < 2);
          e_ps = 1'b1;
          strobe = (s >= 5) && (s <= 10);
          e_rd = !(strobe && !wr);
          e_wr = !(strobe && wr);
          addrph = (s < 3);
          e_oe = addrph || wr;
          e_p0 = addrph ? ad[7:0] : vec[7:0];
          e_p2 = wide ? ad[15:8] : 8'h77;
          t_sl = "R7"; t_oe = wr ? "R9" : "R10";
          t_p0 = addrph ? "R12" : "R9"; t_p2 = "R11";
        end else begin
          ea = (s < 6) ? a0 : a1;
          e_ale = (hp < 2);
          e_ps = !(hp >= 3);
          e_rd = 1'b1;
          e_wr = 1'b1;
          addrph = (hp < 3);
          e_oe = addrph;
          e_p0 = ea[7:0];
          e_p2 = ea[15:8];
          t_sl = "R2"; t_oe = "R3";
          t_p0 = (ld && s < 6) ? "R5" : "R4"; t_p2 = (ld && s < 6) ? "R5" : "R3";
        end
        chk({t_sl, " ale"}, 16'(ale), 16'(e_ale));
        chk({t_sl, " psen_n"}, 16'(psen_n), 16'(e_ps));
        chk("R8 rd_n", 16'(rd_n), 16'(e_rd));
        chk("R8 wr_n", 16'(wr_n), 16'(e_wr));
        chk({t_oe, " p0_oe"}, 16'(p0_oe), 16'(e_oe));
        if (e_oe) chk({t_p0, " p0_out"}, 16'(p0_out), 16'(e_p0));
        chk({t_p2, " p2_out"}, 16'(p2_out), 16'(e_p2));
        if (!isd && s == 6) begin
          chk("R6 instr_valid first half", 16'(instr_valid), 16'h1);
          chk("R6 instr_addr first half", instr_addr, a0);
          chk("R6 instr_data first half", 16'(instr_data), 16'(mem(a0)));
        end
        if (isd && !wr && s == 11) begin
          chk("R10 rd_valid", 16'(rd_valid), 16'h1);
          chk("R10 rd_data", 16'(rd_data), 16'(mem(ad)));
        end
        // only the capture slot carries the real byte; decoy elsewhere
        if (!isd && (s == 5 || s == 11)) p0_in = mem(ea);
        else if (isd && !wr && s == 10) p0_in = mem(ad);
        else p0_in = 8'hEE;
        if (!isd && s == 11) begin
          pend = 1'b1;
          pend_a = a1;
        end
        if (s == 11 && v < NVEC - 1) drive_vec(VEC[v+1]);
      end
    end
    @(negedge clk);
    if (pend) begin
      chk("R6 instr_valid last", 16'(instr_valid), 16'h1);
      chk("R6 instr_addr last", instr_addr, pend_a);
      chk("R6 instr_data last", 16'(instr_data), 16'(mem(pend_a)));
    end
    p0_in = 8'hEE;
    // reset in the middle of a fetch cycle
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run ale", 16'(ale), 16'h0);
    chk("R1 mid-run psen_n", 16'(psen_n), 16'h1);
    chk("R1 mid-run p0_oe", 16'(p0_oe), 16'h0);
    chk("R1 mid-run p2_out", 16'(p2_out), 16'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 restart ale", 16'(ale), 16'h1);
    chk("R4 restart low address", 16'(p0_out), 16'h00);
    chk("R4 restart high address", 16'(p2_out), 16'h00);
    repeat (3) @(negedge clk);
    chk("R2 restart psen_n slot 3", 16'(psen_n), 16'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule